// File: doc/BRIEF.md
# Watch Interval Timer

This block is a free-running watch counter that advances on a subclock enable and raises a periodic interval flag. Software picks one of eight intervals through an 8-bit control/status register on a plain CPU bus. The flag drives an interrupt request when its enable is set. Software can also clear the counter, and it can read whether the subclock has finished its stabilization wait.

The register also holds a select bit that decides which clock source feeds the watchdog. This output is forced to the watch source while the subclock runs the system. In stop mode the counter is held at zero, the flag is cleared and the stabilization wait restarts. Hardware standby clears the flag.

Top module: `wtimer_ctrl`

## Requirements
- R1: After the asynchronous reset, the register reads 8'h88: bit 7 (watchdog source) is 1, bit 3 reads 1, and all other bits are 0. `irq_o` and `stable_o` are 0, and `wdog_tb_sel_o` is 1 while `sub_active_i` is 0.
- R2: `stable_o` and register bit 6 go to 1 at the edge that completes the 2^STAB_W-th subclock tick after reset or after stop mode ends. They are 0 during the wait and stay 1 until the next stop.
- R3: Interval code k in bits 2..0 taps counter bit CNT_W-8+k. The flag (bit 4) goes to 1 one cycle after that bit rises. After a counter clear, the first flag comes 2^(CNT_W-8+k)+1 ticks later, and later flags come every 2^(CNT_W-7+k) ticks.
- R4: `irq_o` is 1 exactly when the flag and the interrupt enable (bit 5) are both 1, and it follows them in the same cycle.
- R5: A write with bit 4 at 0 clears the flag. A write with bit 4 at 1 leaves the flag unchanged.
- R6: When a flag-set event and a flag-clearing write fall on the same edge, the flag ends up 1.
- R7: While `stop_i` is 1, the counter is held at zero, the flag is cleared and the stabilization status is cleared. While `hstby_i` is 1, the flag is cleared.
- R8: A write with bit 3 at 0 clears the counter. A write with bit 3 at 1 does not touch it. Bit 3 always reads 1.
- R9: A read with `rmw_i` at 1 returns 1 in bit 4, whatever the flag holds.
- R10: `wdog_tb_sel_o` equals register bit 7 while `sub_active_i` is 0, and is 0 while `sub_active_i` is 1.
- R11: The counter advances only in cycles where `sub_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_en_i | input | 1 | One-cycle subclock tick enable |
| sub_active_i | input | 1 | Subclock is the current system clock |
| stop_i | input | 1 | Stop mode active |
| hstby_i | input | 1 | Hardware standby active |
| addr_i | input | ADDR_W | Bus address |
| we_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rmw_i | input | 1 | Current read belongs to a read-modify-write |
| rdata_o | output | 8 | Register read data, 0 when not addressed |
| irq_o | output | 1 | Interval interrupt request |
| stable_o | output | 1 | Subclock stabilization wait finished |
| wdog_tb_sel_o | output | 1 | 1 selects the timebase source for the watchdog clock |

## Verification
A write lands on the edge after its bus cycle. Counter clears, flag clears and select changes show on the read port right after that edge. The interval flag shows one cycle after its counter bit rises, and `irq_o` and read data follow with no delay. The stabilization status shows at the edge of its last counted tick. The bench drives inputs and samples outputs on falling edges, and counts every wait in whole cycles from the write or mode edge. Each check therefore falls on the first cycle where a value must hold, and again on the cycle just before.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int REG_W    = 8;
  localparam int IVAL_W   = 3;
  localparam int N_TAP    = 1 << IVAL_W;
  localparam int B_WDTB   = 7;
  localparam int B_STABLE = 6;
  localparam int B_IRQEN  = 5;
  localparam int B_FLAG   = 4;
  localparam int B_CLRN   = 3;

  typedef struct packed {
    logic              wd_tb;
    logic              stable;
    logic              irq_en;
    logic              flag;
    logic              clr_n;
    logic [IVAL_W-1:0] ival;
  } wt_reg_t;
endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W  = 15,
  parameter int IVAL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_en_i,
  input  logic              hold_i,
  input  logic              clr_i,
  input  logic [IVAL_W-1:0] ival_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tick_o
);
  localparam int N_TAP  = 1 << IVAL_W;
  localparam int TAP_LO = CNT_W - N_TAP;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [N_TAP-1:0] taps;
  logic             tap_q;

  for (genvar g = 0; g < N_TAP; g++) begin : g_tap
    assign taps[g] = cnt_q[TAP_LO+g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      if (hold_i || clr_i) cnt_q <= '0;
      else if (sub_en_i)   cnt_q <= cnt_q + ONE;
      tap_q <= taps[ival_i];
    end
  end

  // rising edge of the selected tap
  assign tick_o = taps[ival_i] & ~tap_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wt_stab.sv
module wt_stab #(
  parameter int STAB_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sub_en_i,
  input  logic stop_i,
  output logic stable_o
);
  localparam logic [STAB_W-1:0] ONE = 1;

  logic [STAB_W-1:0] wait_q;
  logic              stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= '0;
      stable_q <= 1'b0;
    end else if (stop_i) begin
      wait_q   <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q && sub_en_i) begin
      wait_q <= wait_q + ONE;
      if (&wait_q) stable_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  wt_reg_t           wd_i,
  input  logic              tick_i,
  input  logic              sleep_i,
  input  logic              stable_i,
  input  logic              sub_active_i,
  input  logic              rmw_i,
  output wt_reg_t           rd_o,
  output logic [IVAL_W-1:0] ival_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wdog_tb_o
);
  logic              wd_tb_q, irq_en_q, flag_q;
  logic [IVAL_W-1:0] ival_q;
  logic              wd_unused;

  assign wd_unused = wd_i.stable ^ wd_i.clr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_tb_q  <= 1'b1;
      irq_en_q <= 1'b0;
      ival_q   <= '0;
    end else if (wr_i) begin
      wd_tb_q  <= wd_i.wd_tb;
      irq_en_q <= wd_i.irq_en;
      ival_q   <= wd_i.ival;
    end
  end

  // low-power entry beats a set event; a set event beats a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (sleep_i)                 flag_q <= 1'b0;
    else if (tick_i)                  flag_q <= 1'b1;
    else if (wr_i && !wd_i.flag)      flag_q <= 1'b0;
  end

  always_comb begin
    rd_o        = '0;
    rd_o.wd_tb  = wd_tb_q;
    rd_o.stable = stable_i;
    rd_o.irq_en = irq_en_q;
    rd_o.flag   = flag_q | rmw_i;
    rd_o.clr_n  = 1'b1;
    rd_o.ival   = ival_q;
  end

  assign ival_o    = ival_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & irq_en_q;
  assign wdog_tb_o = wd_tb_q & ~sub_active_i;
endmodule

// File: rtl/wtimer_ctrl.sv
module wtimer_ctrl
  import wt_pkg::*;
#(
  parameter int                CNT_W    = 15,
  parameter int                STAB_W   = 14,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_en_i,
  input  logic              sub_active_i,
  input  logic              stop_i,
  input  logic              hstby_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              rmw_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              stable_o,
  output logic              wdog_tb_sel_o
);
  wt_reg_t           wd, rd;
  logic              reg_hit, wr, cnt_clr, flag_wr0, tick, flag_q;
  logic [IVAL_W-1:0] ival;
  logic [CNT_W-1:0]  cnt_q;

  assign wd       = wt_reg_t'(wdata_i);
  assign reg_hit  = (addr_i == REG_ADDR);
  assign wr       = we_i & reg_hit;
  assign cnt_clr  = wr & ~wd.clr_n;
  assign flag_wr0 = wr & ~wd.flag;

  wt_counter #(.CNT_W(CNT_W), .IVAL_W(IVAL_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sub_en_i (sub_en_i),
    .hold_i   (stop_i),
    .clr_i    (cnt_clr),
    .ival_i   (ival),
    .cnt_o    (cnt_q),
    .tick_o   (tick)
  );

  wt_stab #(.STAB_W(STAB_W)) u_stab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sub_en_i (sub_en_i),
    .stop_i   (stop_i),
    .stable_o (stable_o)
  );

  wt_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .wd_i         (wd),
    .tick_i       (tick),
    .sleep_i      (stop_i | hstby_i),
    .stable_i     (stable_o),
    .sub_active_i (sub_active_i),
    .rmw_i        (rmw_i),
    .rd_o         (rd),
    .ival_o       (ival),
    .flag_o       (flag_q),
    .irq_o        (irq_o),
    .wdog_tb_o    (wdog_tb_sel_o)
  );

  assign rdata_o = reg_hit ? rd : '0;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sub_en_i,
  input logic             stop_i,
  input logic             sub_active_i,
  input logic             hit_i,
  input logic             rmw_i,
  input logic [7:0]       rdata_i,
  input logic             stable_i,
  input logic             wdog_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_clr_i,
  input logic             tick_i,
  input logic             flag_i,
  input logic             flag_wr0_i
);
  AST_STABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_i && !stop_i |=> stable_i); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && flag_wr0_i && !stop_i |=> flag_i); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_i == '0) && !flag_i && !stable_i); // R7
  AST_CLR_BIT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> rdata_i[3]); // R8
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_i == '0)); // R8
  AST_RMW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && rmw_i |-> rdata_i[4]); // R9
  AST_WDOG_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_active_i |-> !wdog_i); // R10
  AST_CNT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_en_i && !stop_i && !cnt_clr_i |=> $stable(cnt_i)); // R11
endmodule

bind wtimer_ctrl wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sub_en_i     (sub_en_i),
  .stop_i       (stop_i),
  .sub_active_i (sub_active_i),
  .hit_i        (reg_hit),
  .rmw_i        (rmw_i),
  .rdata_i      (rdata_o),
  .stable_i     (stable_o),
  .wdog_i       (wdog_tb_sel_o),
  .cnt_i        (cnt_q),
  .cnt_clr_i    (cnt_clr),
  .tick_i       (tick),
  .flag_i       (flag_q),
  .flag_wr0_i   (flag_wr0)
);

// File: tb/tb_wtimer_ctrl.sv
module tb_wtimer_ctrl;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 10;
  localparam int STAB_W = 6;
  localparam int TAP_LO = CNT_W - 8;
  localparam int STAB_N = 1 << STAB_W;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sub_en = 1'b1, sub_active = 1'b0, stop = 1'b0, hstby = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0, rmw = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, stable, wdog;

  int n_chk = 0;
  int n_fail = 0;

  wtimer_ctrl #(.CNT_W(CNT_W), .STAB_W(STAB_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sub_en_i(sub_en), .sub_active_i(sub_active),
    .stop_i(stop), .hstby_i(hstby), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rmw_i(rmw), .rdata_o(rdata), .irq_o(irq), .stable_o(stable), .wdog_tb_sel_o(wdog)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {wd_tb, stable(ignored), irq_en, flag, clr_n, ival}
  function automatic logic [7:0] wd(input bit tb, input bit ie, input bit fl,
                                    input bit clr_n, input int k);
    return {tb, 1'b0, ie, fl, clr_n, 3'(k)};
  endfunction

  // called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int flag();
    return int'(rdata[4]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    adv(3);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 rdata", int'(rdata), 8'h88);
    chk("R1 irq", int'(irq), 0);
    chk("R1 stable", int'(stable), 0);
    chk("R1 wdog", int'(wdog), 1);

    // R2 stabilization after reset
    adv(STAB_N - 1);
    chk("R2 stable early", int'(stable), 0);
    adv(1);
    chk("R2 stable", int'(stable), 1);
    chk("R2 bit6", int'(rdata[6]), 1);

    // R10 watchdog source
    sub_active = 1'b1; #1;
    chk("R10 sub active", int'(wdog), 0);
    sub_active = 1'b0; #1;
    chk("R10 main active", int'(wdog), 1);
    wr(wd(0, 0, 0, 1, 0));
    chk("R10 bit7 zero", int'(wdog), 0);

    // R3 R4 R5 sweep over all interval codes
    for (int k = 0; k < 8; k++) begin
      int p;
      p = 1 << (TAP_LO + k);
      wr(wd(1, 1, 0, 0, k));
      adv(p);
      chk($sformatf("R3 k%0d before", k), flag(), 0);
      adv(1);
      chk($sformatf("R3 k%0d first", k), flag(), 1);
      chk($sformatf("R4 k%0d irq", k), int'(irq), 1);
      wr(wd(1, 1, 0, 1, k));
      chk($sformatf("R5 k%0d clear", k), flag(), 0);
      chk($sformatf("R4 k%0d irq off", k), int'(irq), 0);
      adv(2 * p - 2);
      chk($sformatf("R3 k%0d period before", k), flag(), 0);
      adv(1);
      chk($sformatf("R3 k%0d period", k), flag(), 1);
    end

    // R4 enable gating, R5 write-1 no effect (k=0, p=4, period 8)
    wr(wd(1, 0, 0, 0, 0));
    adv(5);
    chk("R4 flag no enable", flag(), 1);
    chk("R4 irq masked", int'(irq), 0);
    wr(wd(1, 1, 1, 1, 0));
    chk("R4 irq enabled", int'(irq), 1);
    chk("R5 write1 keeps 1", flag(), 1);
    wr(wd(1, 1, 0, 1, 0));
    chk("R5 write0 clears", flag(), 0);
    wr(wd(1, 1, 1, 1, 0));
    chk("R5 write1 no set", flag(), 0);

    // R6 set and clear on the same edge
    wr(wd(1, 1, 0, 0, 0));
    adv(4);
    wr(wd(1, 1, 0, 1, 0));
    chk("R6 set wins", flag(), 1);

    // R8 counter clear bit (k=1, p=8)
    wr(wd(1, 1, 0, 0, 1));
    adv(6);
    wr(wd(1, 1, 0, 1, 1));
    adv(1);
    chk("R8 no clear before", flag(), 0);
    adv(1);
    chk("R8 write1 keeps count", flag(), 1);
    chk("R8 bit3 reads 1", int'(rdata[3]), 1);
    wr(wd(1, 1, 0, 0, 1));
    adv(6);
    wr(wd(1, 1, 0, 0, 1));
    adv(2);
    chk("R8 write0 cleared count", flag(), 0);
    adv(6);
    chk("R8 after clear before", flag(), 0);
    adv(1);
    chk("R8 after clear", flag(), 1);

    // R9 read-modify-write read
    wr(wd(1, 1, 0, 1, 1));
    chk("R9 flag clear", flag(), 0);
    rmw = 1'b1; #1;
    chk("R9 rmw read", int'(rdata[4]), 1);
    rmw = 1'b0; #1;
    chk("R9 plain read", int'(rdata[4]), 0);

    // R11 subclock enable gating (k=0, p=4)
    wr(wd(1, 1, 0, 0, 0));
    sub_en = 1'b0;
    adv(10);
    chk("R11 no count", flag(), 0);
    sub_en = 1'b1;
    adv(4);
    chk("R11 before", flag(), 0);
    adv(1);
    chk("R11 delayed flag", flag(), 1);

    // R7 stop mode, R2 restart
    stop = 1'b1;
    adv(3);
    chk("R7 stop flag", flag(), 0);
    chk("R7 stop irq", int'(irq), 0);
    chk("R7 stop stable", int'(stable), 0);
    stop = 1'b0;
    adv(4);
    chk("R7 counter held before", flag(), 0);
    adv(1);
    chk("R7 counter restart", flag(), 1);
    adv(STAB_N - 1 - 5);
    chk("R2 restart early", int'(stable), 0);
    adv(1);
    chk("R2 restart done", int'(stable), 1);
    hstby = 1'b1;
    adv(1);
    hstby = 1'b0;
    chk("R7 standby flag", flag(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule